// File: doc/BRIEF.md
# Modem Event Interrupt Controller

This block gathers the status events of a half-duplex modem into sticky flag bits and drives one interrupt line toward a system controller. Ten events are tracked: the carrier detect signal appearing and disappearing, clear-to-send being granted and withdrawn, and the level-threshold, full and empty conditions of both the receive buffer and the transmit buffer. Each event arrives as a single-cycle pulse. It sets its flag, and the flag stays set until software clears it.

Software reaches the block through a small register port with a combinational read and a write that takes effect on the clock edge. Through this port it reads the flags, clears them by writing ones, chooses which flags may raise the interrupt through a mask, and configures the output. The output can be level style, active while any unmasked flag is set, or edge style, a one-clock pulse for each newly pending flag. It can be active high or active low. It can be routed to one of two pins, depending on the serial interface mode, or disabled.

An output state machine has three states. `ST_IDLE` means the line is inactive. `ST_PULSE` is the single active clock of edge style. `ST_LEVEL` means the line is held active in level style. The transitions are: IDLE→PULSE and PULSE→PULSE on a new pending flag in edge style; IDLE→LEVEL and PULSE→LEVEL when any flag is pending in level style; LEVEL→LEVEL while a flag stays pending in level style; LEVEL→PULSE on a new pending flag after a switch to edge style; and any state→IDLE otherwise.

Top module: `modem_irq_ctrl`

## Requirements
- R1: Flags are read at address 0 with this bit map: 0 carrier-detect appeared, 1 carrier-detect lost, 2 clear-to-send granted, 3 clear-to-send withdrawn, 4 receive level, 5 receive full, 6 receive empty, 7 transmit level, 8 transmit full, 9 transmit empty. A pulse on `evt_pulse[i]` at a clock edge sets flag i from that edge on, and the flag stays set.
- R2: A write to address 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R3: When an event and a write-one clear hit the same flag on the same edge, the flag ends up set.
- R4: The mask is at address 1, one bit per flag in the R1 positions. A mask bit of 1 blocks its flag from the interrupt, and a bit of 0 lets it through.
- R5: Configuration is at address 2, with bit 0 set to 1 for level style. In level style the line is active from the second edge after the event (one edge after the flag is set) for as long as any unmasked flag is set. It goes inactive one edge after the last such flag is cleared.
- R6: With configuration bit 0 at 0 (edge style), each flag that becomes newly pending, by an event or by being unmasked, gives exactly one active clock, starting one edge after it becomes pending. A flag that is already set gives no further pulse.
- R7: Configuration bit 1 set to 1 makes the line active low; 0 makes it active high.
- R8: Configuration bit 2 enables the pin and bit 3 selects the route. When bit 3 is 0 the line drives `irq_uart_pin`; when it is 1 the line drives `irq_sdo_pin`. The pin that is not selected, and both pins when bit 2 is 0, sit at the inactive level.
- R9: After reset, the flags read 0, the mask reads 0x3FF, the configuration reads 0, and both pins are 0.
- R10: Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 10 | Single-cycle event pulses, in the R1 bit positions |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 flags, 1 mask, 2 configuration |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Combinational read data for `reg_addr` |
| irq_uart_pin | output | 1 | Interrupt output when routed in serial-only mode |
| irq_sdo_pin | output | 1 | Interrupt output when routed in break mode |

## Verification
The hardest case to reach is an edge-style pulse that no event pulse causes. This is a flag that is already set becoming pending because its mask bit is written to 0. It has to be set up by raising the flag while it is masked, confirming the line stays quiet, and only then unmasking it. A second hard case is the race between a write-one clear and a new event on the same edge. The bench drives the write strobe and the event pulse together on one falling edge, and also clears a neighbouring bit in the same write to show that only the raced bit survives.

// File: rtl/modem_irq_pkg.sv
package modem_irq_pkg;
    localparam int NUM_EVT = 10;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CFG   = 2'd2;

    typedef struct packed {
        logic brk_mode;    // bit 3: route to the sdo pin
        logic pin_en;      // bit 2: pin enable
        logic act_low;     // bit 1: active low polarity
        logic level_mode;  // bit 0: level style
    } irq_cfg_t;

    localparam int CFG_W = $bits(irq_cfg_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_LEVEL = 2'd2
    } irq_state_e;
endpackage

// File: rtl/modem_irq_regs.sv
module modem_irq_regs
    import modem_irq_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    input  logic [N-1:0]      flags,
    output logic [N-1:0]      reg_rdata,
    output logic [N-1:0]      clr_vec,
    output logic [N-1:0]      mask_q,
    output irq_cfg_t          cfg_q
);
    localparam int PAD_W = N - CFG_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            cfg_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_MASK) mask_q <= reg_wdata;
            if (reg_addr == ADDR_CFG)  cfg_q  <= irq_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    always_comb begin
        clr_vec = (reg_wr && reg_addr == ADDR_FLAGS) ? reg_wdata : '0;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_FLAGS: reg_rdata = flags;
            ADDR_MASK:  reg_rdata = mask_q;
            ADDR_CFG:   reg_rdata = {{PAD_W{1'b0}}, cfg_q};
            default:    reg_rdata = '0;
        endcase
    end

    // R10: a write to the spare address leaves mask and configuration alone
    assert_spare_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3) |=> ($stable(mask_q) && $stable(cfg_q)));
endmodule

// File: rtl/modem_irq_flags.sv
module modem_irq_flags
    import modem_irq_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= evt[i] | (flags[i] & ~clr[i]);
        end
    end

    assert_event_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

    assert_flag_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != '0) |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

    assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~evt) != '0) |=> ((flags & $past(clr & ~evt)) == '0));

    assert_set_beats_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & evt) != '0) |=> ((flags & $past(clr & evt)) == $past(clr & evt)));
endmodule

// File: rtl/modem_irq_fsm.sv
module modem_irq_fsm
    import modem_irq_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    input  logic         level_mode,
    output logic         irq_act
);
    irq_state_e  state_q, state_d;
    logic [N-1:0] pend, pend_prev_q, new_bits;
    logic         any_pend, any_new;

    assign pend     = flags & ~mask;
    assign new_bits = pend & ~pend_prev_q;
    assign any_pend = |pend;
    assign any_new  = |new_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            pend_prev_q <= '0;
        end else begin
            state_q     <= state_d;
            pend_prev_q <= pend;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_PULSE: begin
                if (level_mode && any_pend)  state_d = ST_LEVEL;
                else if (!level_mode && any_new) state_d = ST_PULSE;
            end
            ST_LEVEL: begin
                if (level_mode) state_d = any_pend ? ST_LEVEL : ST_IDLE;
                else            state_d = any_new  ? ST_PULSE : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_act = (state_q == ST_PULSE) || (state_q == ST_LEVEL);
    end

    assert_level_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && any_pend) |=> irq_act);

    assert_level_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_mode && !any_pend) |=> !irq_act);

    assert_edge_single_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && !any_new) |=> !irq_act);

    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_pend) |=> !irq_act);
endmodule

// File: rtl/modem_irq_ctrl.sv
module modem_irq_ctrl
    import modem_irq_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      evt_pulse,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [N-1:0]      reg_wdata,
    output logic [N-1:0]      reg_rdata,
    output logic              irq_uart_pin,
    output logic              irq_sdo_pin
);
    logic [N-1:0] flags, clr_vec, mask_q;
    irq_cfg_t     cfg_q;
    logic         irq_act, line;

    modem_irq_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .flags(flags), .reg_rdata(reg_rdata),
        .clr_vec(clr_vec), .mask_q(mask_q), .cfg_q(cfg_q)
    );

    modem_irq_flags #(.N(N)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(clr_vec), .flags(flags)
    );

    modem_irq_fsm #(.N(N)) u_fsm (
        .clk(clk), .rst_n(rst_n), .flags(flags), .mask(mask_q),
        .level_mode(cfg_q.level_mode), .irq_act(irq_act)
    );

    assign line         = irq_act ^ cfg_q.act_low;
    assign irq_uart_pin = (cfg_q.pin_en && !cfg_q.brk_mode) ? line : cfg_q.act_low;
    assign irq_sdo_pin  = (cfg_q.pin_en &&  cfg_q.brk_mode) ? line : cfg_q.act_low;

    // R8: never both pins at the active level
    assert_single_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((irq_uart_pin ^ cfg_q.act_low) && (irq_sdo_pin ^ cfg_q.act_low)));

    // R7: routed pin shows the activity through the configured polarity
    assert_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.pin_en && !cfg_q.brk_mode) |-> (irq_uart_pin == (irq_act ^ cfg_q.act_low)));
endmodule

// File: tb/test_modem_irq_ctrl.sv
`timescale 1ns/1ps
module test_modem_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] evt_pulse = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       irq_uart_pin, irq_sdo_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    modem_irq_ctrl i_modem_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_uart_pin(irq_uart_pin), .irq_sdo_pin(irq_sdo_pin)
    );

    // {evt, mask, cfg, uart pin, sdo pin}; cfg bits {route, pin_en, act_low, level}
    localparam logic [25:0] VECS [0:7] = '{
        {10'h001, 10'h3FE, 4'b0101, 1'b1, 1'b0},
        {10'h002, 10'h3FE, 4'b0101, 1'b0, 1'b0},
        {10'h200, 10'h1FF, 4'b1101, 1'b0, 1'b1},
        {10'h010, 10'h000, 4'b0111, 1'b0, 1'b1},
        {10'h0A0, 10'h3DF, 4'b1111, 1'b1, 1'b0},
        {10'h004, 10'h000, 4'b0001, 1'b0, 1'b0},
        {10'h300, 10'h0FF, 4'b0011, 1'b1, 1'b1},
        {10'h048, 10'h3B7, 4'b0101, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [9:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [9:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] d;
        repeat (3) @(negedge clk);
        // R9 reset state
        rd(2'd0, d); chk("R9 flags", d, 10'h000);
        rd(2'd1, d); chk("R9 mask", d, 10'h3FF);
        rd(2'd2, d); chk("R9 cfg", d, 10'h000);
        chk("R9 pins", {irq_uart_pin, irq_sdo_pin}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 pins after release", {irq_uart_pin, irq_sdo_pin}, 2'b00);

        // vector table: R1 R4 R5 R7 R8 in level style
        for (int k = 0; k < 8; k++) begin
            wr(2'd2, {6'b0, VECS[k][5:2]});
            wr(2'd1, VECS[k][15:6]);
            wr(2'd0, 10'h3FF);
            @(negedge clk);
            pulse(VECS[k][25:16]);
            @(negedge clk);
            rd(2'd0, d);
            chk($sformatf("R1 vec%0d flags", k), d, VECS[k][25:16]);
            chk($sformatf("R4/R5/R7/R8 vec%0d pins", k),
                {irq_uart_pin, irq_sdo_pin}, VECS[k][1:0]);
        end

        // R2 write-one clear
        wr(2'd0, 10'h3FF);
        pulse(10'h003);
        wr(2'd0, 10'h001);
        rd(2'd0, d); chk("R2 clear bit0", d, 10'h002);
        wr(2'd0, 10'h000);
        rd(2'd0, d); chk("R2 zero write", d, 10'h002);

        // R3 set beats clear on the same edge; bit 3 cleared alongside
        wr(2'd0, 10'h3FF);
        pulse(10'h008);
        @(negedge clk);
        evt_pulse = 10'h004; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 10'h00C;
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0;
        rd(2'd0, d); chk("R3 race", d, 10'h004);

        // R5 level drop timing
        wr(2'd2, 10'h005);
        wr(2'd1, 10'h000);
        wr(2'd0, 10'h3FF);
        @(negedge clk);
        pulse(10'h010);
        chk("R5 not yet active", irq_uart_pin, 1'b0);
        @(negedge clk);
        chk("R5 active", irq_uart_pin, 1'b1);
        wr(2'd0, 10'h010);
        chk("R5 still active one edge after clear", irq_uart_pin, 1'b1);
        @(negedge clk);
        chk("R5 inactive", irq_uart_pin, 1'b0);

        // R8 disable while active
        pulse(10'h010);
        @(negedge clk);
        chk("R8 active before disable", irq_uart_pin, 1'b1);
        wr(2'd2, 10'h001);
        chk("R8 disabled pins", {irq_uart_pin, irq_sdo_pin}, 2'b00);

        // R6 edge style
        wr(2'd2, 10'h004);
        wr(2'd0, 10'h3FF);
        @(negedge clk);
        pulse(10'h001);
        chk("R6 before pulse", irq_uart_pin, 1'b0);
        @(negedge clk);
        chk("R6 pulse", irq_uart_pin, 1'b1);
        @(negedge clk);
        chk("R6 pulse ends", irq_uart_pin, 1'b0);
        pulse(10'h001);
        chk("R6 repeat no pulse a", irq_uart_pin, 1'b0);
        @(negedge clk);
        chk("R6 repeat no pulse b", irq_uart_pin, 1'b0);
        wr(2'd1, 10'h002);
        pulse(10'h002);
        @(negedge clk);
        chk("R4 masked edge quiet", irq_uart_pin, 1'b0);
        wr(2'd1, 10'h000);
        chk("R6 unmask before pulse", irq_uart_pin, 1'b0);
        @(negedge clk);
        chk("R6 unmask pulse", irq_uart_pin, 1'b1);
        @(negedge clk);
        chk("R6 unmask pulse ends", irq_uart_pin, 1'b0);

        // R7 active-low edge pulse
        wr(2'd2, 10'h006);
        wr(2'd0, 10'h3FF);
        chk("R7 idle high", irq_uart_pin, 1'b1);
        pulse(10'h200);
        @(negedge clk);
        chk("R7 low pulse", irq_uart_pin, 1'b0);
        @(negedge clk);
        chk("R7 back high", irq_uart_pin, 1'b1);

        // R10 spare address
        wr(2'd1, 10'h155);
        wr(2'd3, 10'h3FF);
        rd(2'd3, d); chk("R10 spare reads zero", d, 10'h000);
        rd(2'd1, d); chk("R10 mask unchanged", d, 10'h155);
        rd(2'd2, d); chk("R10 cfg unchanged", d, 10'h006);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule